// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a flash memory. Once a program or erase command has been issued, the block reads the status byte at one chosen address again and again until the memory reports that the operation is over. The caller pulses `start` and supplies two values. The first is the byte that was written; for an erase this is all ones, because erased cells read back as ones. The second is an address that the operation affects. Each read is a single-cycle request on a synchronous read port, and the reply is marked by `rd_valid`, which may arrive any number of cycles later.

The most significant bit of the status byte is the completion flag. While the memory is still busy, this bit reads as the inverse of the expected bit 7. When the operation ends, it reads as the true value. Bit 5 is the memory's time-limit error flag. The two bits may change in the same cycle, so when bit 5 is seen the block reads the status once more and decides on that second read. The top bit can also settle before the lower bits. For that reason, a successful result is followed by one more read, and the byte from that read is returned as the verified data. An optional limit on the number of polls ends a run that neither completes nor raises the error flag.

The state machine has eight states. IDLE waits for `start`. POLL_REQ and POLL_WAIT issue a poll and wait for its reply. RECHK_REQ and RECHK_WAIT perform the single re-read after the error flag. FETCH_REQ and FETCH_WAIT perform the read that collects the final byte. FINISH raises `done` for one cycle and then returns to IDLE. The transitions are:
- IDLE to POLL_REQ on `start`.
- Each REQ state to its WAIT state unconditionally.
- POLL_WAIT to FETCH_REQ on a match.
- POLL_WAIT to RECHK_REQ on a mismatch with bit 5 set.
- POLL_WAIT to POLL_REQ on a mismatch with bit 5 clear and the limit not reached.
- POLL_WAIT to FINISH on a mismatch with bit 5 clear and the limit reached.
- RECHK_WAIT to FETCH_REQ on a match.
- RECHK_WAIT to FINISH on a mismatch.
- FETCH_WAIT to FINISH on the reply.

Top module: `status_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail` and `rd_req` are low and `verified_data` is zero.
- R2: A `start` in IDLE latches the expected byte and the address. Every read presents the latched address on `rd_addr`. `rd_req` is high for exactly one cycle per read, and no new request is issued before `rd_valid` returns the full byte.
- R3: When bit 7 of a returned status byte equals bit 7 of the expected byte, the block does not fail and continues to the final read.
- R4: When bit 7 mismatches and bit 5 is 0, the block issues another poll, as long as the poll limit has not been reached.
- R5: When bit 7 mismatches and bit 5 is 1, the block issues exactly one re-read. If bit 7 of that re-read matches, the outcome is pass.
- R6: If bit 7 of the re-read mismatches, the block ends with `fail` and issues no further read.
- R7: After a match, the block issues exactly one more read and ends with `pass`, showing that read's whole byte on `verified_data`.
- R8: With an expected byte of 8'hFF (erase), a status byte whose bit 7 is 1 counts as completion.
- R9: With `MAX_POLLS` nonzero, the block ends with `fail` after `MAX_POLLS` consecutive polls that show a bit 7 mismatch with bit 5 at 0. A value of zero removes the limit.
- R10: `done` is a single-cycle pulse. `pass` and `fail` are never high together, are valid in the cycle that `done` is high, and hold until the next accepted `start`. `busy` is high from the cycle after `start` through the cycle of `done`.
- R11: A `start` while `busy` is high is ignored; the run continues with the values latched at the start of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling run (accepted only when idle) |
| exp_data | input | DW | Byte that was programmed; all ones for erase |
| poll_addr | input | AW | Address to poll |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read reply strobe |
| rd_data | input | DW | Read reply byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run ended in success |
| fail | output | 1 | Run ended in failure |
| verified_data | output | DW | Byte from the read that follows a match |

## Verification
The bench builds the block with `DW` at 8, `AW` at 16 and `MAX_POLLS` at 4. A limit of four polls lets the time-out path be reached in only a few reads, instead of the long run the unlimited setting would need. The bench's memory model replies after a delay chosen per scenario, from zero to three cycles, so every wait state is tested both with an immediate reply and with a long stall. The model also counts the reads it serves, which shows that the re-read and the final read each happen exactly once.

// File: rtl/spoll_pkg.sv
package spoll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_RECHK_REQ,
        ST_RECHK_WAIT,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_FINISH
    } spoll_state_t;

    localparam int unsigned ERR_BIT = 5;
endpackage

// File: rtl/spoll_judge.sv
module spoll_judge #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] status,
    input  logic          want_msb,
    output logic          match,
    output logic          err_flag
);
    localparam int MSB = DW - 1;

    always_comb begin
        match    = (status[MSB] == want_msb);
        err_flag = status[spoll_pkg::ERR_BIT];
    end
endmodule

// File: rtl/spoll_limit.sv
module spoll_limit #(
    parameter int MAX_POLLS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    generate
        if (MAX_POLLS == 0) begin : g_unlimited
            assign hit = 1'b0;
        end else begin : g_limited
            localparam int CW = $clog2(MAX_POLLS + 1);
            localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || clr) cnt <= '0;
                else if (inc && cnt != LAST) cnt <= cnt + 1'b1;
            end

            assign hit = (cnt == LAST);

            // R9: the count never runs past the last allowed poll
            assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
                cnt <= LAST);
        end
    endgenerate
endmodule

// File: rtl/status_poll_ctrl.sv
module status_poll_ctrl #(
    parameter int DW        = 8,
    parameter int AW        = 16,
    parameter int MAX_POLLS = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] exp_data,
    input  logic [AW-1:0] poll_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic [DW-1:0] verified_data
);
    import spoll_pkg::*;

    spoll_state_t state, nxt;
    logic [AW-1:0] addr_q;
    logic          want_q;
    logic          match, err_flag, lim_hit;
    logic          accept, poll_again;

    spoll_judge #(.DW(DW)) u_judge (
        .status   (rd_data),
        .want_msb (want_q),
        .match    (match),
        .err_flag (err_flag)
    );

    assign accept     = (state == ST_IDLE) && start;
    assign poll_again = (state == ST_POLL_WAIT) && rd_valid && !match && !err_flag;

    spoll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (poll_again),
        .hit   (lim_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (start) nxt = ST_POLL_REQ;
            ST_POLL_REQ:   nxt = ST_POLL_WAIT;
            ST_POLL_WAIT:
                if (rd_valid) begin
                    if (match)         nxt = ST_FETCH_REQ;
                    else if (err_flag) nxt = ST_RECHK_REQ;
                    else if (lim_hit)  nxt = ST_FINISH;
                    else               nxt = ST_POLL_REQ;
                end
            ST_RECHK_REQ:  nxt = ST_RECHK_WAIT;
            ST_RECHK_WAIT:
                if (rd_valid) nxt = match ? ST_FETCH_REQ : ST_FINISH;
            ST_FETCH_REQ:  nxt = ST_FETCH_WAIT;
            ST_FETCH_WAIT: if (rd_valid) nxt = ST_FINISH;
            ST_FINISH:     nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        rd_req = (state == ST_POLL_REQ) || (state == ST_RECHK_REQ) || (state == ST_FETCH_REQ);
        busy   = (state != ST_IDLE);
        done   = (state == ST_FINISH);
    end

    // latched run context and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q        <= '0;
            want_q        <= 1'b0;
            pass          <= 1'b0;
            fail          <= 1'b0;
            verified_data <= '0;
        end else if (accept) begin
            addr_q        <= poll_addr;
            want_q        <= exp_data[DW-1];
            pass          <= 1'b0;
            fail          <= 1'b0;
            verified_data <= '0;
        end else if (rd_valid) begin
            if (poll_again && lim_hit)                        fail <= 1'b1;
            if (state == ST_RECHK_WAIT && !match)             fail <= 1'b1;
            if (state == ST_FETCH_WAIT) begin
                pass          <= 1'b1;
                verified_data <= rd_data;
            end
        end
    end

    assign rd_addr = addr_q;

    // R10: never both outcomes
    assert_outcome_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));
    // R10: done lasts one cycle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: request is a one-cycle pulse
    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R11: address held for the whole run
    assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_addr));
    // R6: failed re-read ends the run at once with fail
    assert_recheck_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECHK_WAIT && rd_valid && !match) |=> (done && fail));
    // R7: a match leads straight to the final read request
    assert_match_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_WAIT && rd_valid && match) |=> rd_req);
endmodule

// File: tb/status_poll_ctrl_test.sv
module status_poll_ctrl_test;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int MAXP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] exp_data = '0;
    logic [AW-1:0] poll_addr = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          busy, done, pass, fail;
    logic [DW-1:0] verified_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] script [16];
    int idx = 0;
    int reads = 0;
    int lat = 0;
    int addr_bad = 0;
    logic [AW-1:0] addr_exp = '0;

    always #5 clk = ~clk;

    status_poll_ctrl #(.DW(DW), .AW(AW), .MAX_POLLS(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_data(exp_data),
        .poll_addr(poll_addr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .verified_data(verified_data)
    );

    // memory model: serves scripted bytes after lat cycles
    initial begin
        forever begin
            @(posedge clk);
            if (rd_req) begin
                if (rd_addr !== addr_exp) addr_bad++;
                repeat (lat) @(posedge clk);
                rd_data  <= script[idx];
                rd_valid <= 1'b1;
                idx++;
                reads++;
                @(posedge clk);
                rd_valid <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic launch(input logic [DW-1:0] e, input logic [AW-1:0] a, input int l);
        idx = 0; reads = 0; addr_bad = 0; lat = l; addr_exp = a;
        @(negedge clk);
        exp_data = e; poll_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", int'(busy), 1);
    endtask

    task automatic finish_run(input string req, input int exp_pass, input int exp_rd,
                              input int exp_ver);
        int guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check({req, " done seen"}, int'(done), 1);
        check({req, " pass"}, int'(pass), exp_pass);
        check({req, " fail"}, int'(fail), 1 - exp_pass);
        check({req, " read count"}, reads, exp_rd);
        check({req, " verified byte"}, int'(verified_data), exp_ver);
        check("R2 address on every read", addr_bad, 0);
        @(negedge clk);
        check("R10 done single cycle", int'(done), 0);
        check("R10 busy clear", int'(busy), 0);
        check("R10 outcome held", int'(pass), exp_pass);
    endtask

    task automatic t_reset;
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 pass", int'(pass), 0);
        check("R1 fail", int'(fail), 0);
        check("R1 rd_req", int'(rd_req), 0);
        check("R1 verified", int'(verified_data), 0);
    endtask

    task automatic t_program_pass;   // R3 R4 R7
        script[0] = 8'h80; script[1] = 8'h80; script[2] = 8'h1A; script[3] = 8'h5A;
        launch(8'h5A, 16'h1234, 0);
        finish_run("R7 program", 1, 4, 8'h5A);
    endtask

    task automatic t_erase_pass;     // R8
        script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h83; script[3] = 8'hFF;
        launch(8'hFF, 16'h0F00, 2);
        finish_run("R8 erase", 1, 4, 8'hFF);
    endtask

    task automatic t_err_then_pass;  // R5
        script[0] = 8'hA0; script[1] = 8'h20; script[2] = 8'h00;
        launch(8'h00, 16'h00AA, 1);
        finish_run("R5 recheck pass", 1, 3, 8'h00);
    endtask

    task automatic t_err_then_fail;  // R6
        script[0] = 8'h20; script[1] = 8'h20; script[2] = 8'h80;
        launch(8'h80, 16'h5555, 0);
        finish_run("R6 recheck fail", 0, 2, 8'h00);
    endtask

    task automatic t_limit;          // R9
        for (int i = 0; i < 8; i++) script[i] = 8'h00;
        launch(8'h80, 16'h7777, 1);
        finish_run("R9 poll limit", 0, MAXP, 8'h00);
    endtask

    task automatic t_start_ignored;  // R11
        script[0] = 8'h80; script[1] = 8'h00; script[2] = 8'h3C;
        launch(8'h3C, 16'h2468, 3);
        @(negedge clk);
        exp_data = 8'hFF; poll_addr = 16'hDEAD; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_run("R11 start while busy", 1, 3, 8'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_pass();
        t_erase_pass();
        t_err_then_pass();
        t_err_then_fail();
        t_limit();
        t_start_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end
endmodule